// File: doc/BRIEF.md
# TLB Access Fault Classifier

This block sits next to the instruction-side and data-side translation lookaside buffers. It does not do the lookup. Each cycle it receives the lookup result and the attributes of the matching entry for one instruction fetch and one data access. For each side it decides whether the access faults, and whether the fault is a miss or an error. It then reports at most one exception per cycle.

Each report is a one-cycle strobe and carries:
- the side that faulted (instruction or data),
- a miss/error flag,
- a handler vector offset,
- a one-hot cause word, and
- the faulting effective address. The address stays latched until the next report.

When both sides fault in the same cycle, the fetch fault is reported first. The data fault is parked until the core acknowledges with `exc_ack`, and is reported on the cycle after that acknowledge.

Top module: `tlb_fault_classifier`

## Requirements
- R1: A fetch with `f_req`=1, `f_xlat_en`=1 and `f_hit`=0 produces, one cycle later, `exc`=1, `exc_data`=0, `exc_miss`=1, `exc_vec`=0x1100, `exc_cause`=0 and `fault_ea` equal to `f_ea`.
- R2: A data access with `d_req`=1, `d_xlat_en`=1 and `d_hit`=0 produces, one cycle later, `exc`=1, `exc_data`=1, `exc_miss`=1, `exc_vec`=0x1200, `exc_cause`=0 and `fault_ea` equal to `d_ea`.
- R3: A side whose translation enable is 0 never raises an exception, whatever its hit and attribute inputs are.
- R4: A fetch that hits with translation on raises an error with `exc_vec`=0x1300 when any of these hold: `f_page_ok`=0 (cause bit 0), `f_seg_ok`=0 (cause bit 1), `f_exec_ok`=0 (cause bit 2), or `f_guarded`=1 (cause bit 3). Cause bit 4 is never set on a fetch error. A fetch hit with none of these conditions raises nothing.
- R5: A data access that hits with translation on raises an error with `exc_vec`=0x1400 when any of these hold: page invalid (bit 0), segment invalid (bit 1), or a protection failure (bit 2). `d_kind` encodes 00 as load, 01 as store, and 10 or 11 as a cache-block operation. A protection failure is `d_wr_ok`=0 for a store, and `d_rd_ok`=0 for a load or a cache-block operation.
- R6: A store that hits a page with `d_dirty`=0 sets cause bit 4 (clean-page write). A load or a cache-block operation on such a page does not fault on that account.
- R7: On a miss, the entry attributes are ignored: the cause word is zero and the miss vector is used.
- R8: When several error conditions hold for one access, all of their cause bits are reported together in a single exception.
- R9: When both sides fault in one cycle, the fetch fault is reported first. The data fault is reported one cycle after the first `exc_ack` that follows, with `fault_ea` equal to that access's `d_ea`.
- R10: While a data fault is parked, new accesses on both sides are ignored. An `exc_ack` with nothing parked has no effect.
- R11: `exc` is a single-cycle strobe for each report, and `fault_ea` does not change on cycles without a report.
- R12: After reset, `exc`=0, `exc_cause`=0 and `fault_ea`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_req | input | 1 | Instruction fetch present this cycle |
| f_xlat_en | input | 1 | Instruction translation enabled |
| f_hit | input | 1 | Instruction TLB hit |
| f_seg_ok | input | 1 | Segment valid bit of the matched instruction entry |
| f_page_ok | input | 1 | Page valid bit of the matched instruction entry |
| f_exec_ok | input | 1 | Fetch permitted by the entry's protection |
| f_guarded | input | 1 | Matched page is guarded |
| f_ea | input | EA_W | Fetch effective address |
| d_req | input | 1 | Data access present this cycle |
| d_xlat_en | input | 1 | Data translation enabled |
| d_hit | input | 1 | Data TLB hit |
| d_kind | input | 2 | 00 load, 01 store, 1x cache-block operation |
| d_seg_ok | input | 1 | Segment valid bit of the matched data entry |
| d_page_ok | input | 1 | Page valid bit of the matched data entry |
| d_rd_ok | input | 1 | Read permitted by the entry's protection |
| d_wr_ok | input | 1 | Write permitted by the entry's protection |
| d_dirty | input | 1 | Change bit of the matched data page |
| d_ea | input | EA_W | Data effective address |
| exc_ack | input | 1 | Acknowledge of the reported exception; releases a parked data fault |
| exc | output | 1 | Exception strobe |
| exc_data | output | 1 | 1 = data side, 0 = instruction side |
| exc_miss | output | 1 | 1 = miss, 0 = error |
| exc_vec | output | VEC_W | Handler vector offset |
| exc_cause | output | 5 | One-hot cause bits: 0 page invalid, 1 segment invalid, 2 protection, 3 guarded, 4 clean-page write |
| fault_ea | output | EA_W | Latched faulting effective address |

## Verification
Single-side patterns come first. A miss with translation on and with translation off shows that the enable bit gates every exception. A miss with every attribute set bad shows that a miss takes priority over error causes. Hits are then tried with one bad attribute at a time and then with several at once. This confirms each cause bit on its own and shows that causes combine rather than being prioritised. Stores, loads and cache-block operations are each run against the read, write and change permissions, which shows that each access type checks the right permission. Finally, a cycle in which both sides miss or err, followed by extra accesses before and after the acknowledge, confirms the reporting order, the parking of the data fault, and that no new fault slips in while one is parked.

// File: rtl/tlb_fault_classifier.sv
module tlb_fault_classifier #(
  parameter int EA_W = 32,
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_IMISS = 16'h1100,
  parameter logic [VEC_W-1:0] VEC_DMISS = 16'h1200,
  parameter logic [VEC_W-1:0] VEC_IERR  = 16'h1300,
  parameter logic [VEC_W-1:0] VEC_DERR  = 16'h1400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             f_req,
  input  logic             f_xlat_en,
  input  logic             f_hit,
  input  logic             f_seg_ok,
  input  logic             f_page_ok,
  input  logic             f_exec_ok,
  input  logic             f_guarded,
  input  logic [EA_W-1:0]  f_ea,
  input  logic             d_req,
  input  logic             d_xlat_en,
  input  logic             d_hit,
  input  logic [1:0]       d_kind,
  input  logic             d_seg_ok,
  input  logic             d_page_ok,
  input  logic             d_rd_ok,
  input  logic             d_wr_ok,
  input  logic             d_dirty,
  input  logic [EA_W-1:0]  d_ea,
  input  logic             exc_ack,
  output logic             exc,
  output logic             exc_data,
  output logic             exc_miss,
  output logic [VEC_W-1:0] exc_vec,
  output logic [4:0]       exc_cause,
  output logic [EA_W-1:0]  fault_ea
);

  logic f_go, f_miss, f_flt, d_go, d_miss, d_flt, d_store;
  logic [4:0] f_cause, d_cause;

  assign f_go    = f_req & f_xlat_en;
  assign f_miss  = f_go & ~f_hit;
  assign f_cause = (f_go & f_hit) ? {1'b0, f_guarded, ~f_exec_ok, ~f_seg_ok, ~f_page_ok} : 5'b0;
  assign f_flt   = f_miss | (|f_cause);

  assign d_store = (d_kind == 2'b01);
  assign d_go    = d_req & d_xlat_en;
  assign d_miss  = d_go & ~d_hit;
  assign d_cause = (d_go & d_hit) ?
                   {d_store & ~d_dirty, 1'b0, d_store ? ~d_wr_ok : ~d_rd_ok, ~d_seg_ok, ~d_page_ok} : 5'b0;
  assign d_flt   = d_miss | (|d_cause);

  logic            pend_q, pend_miss;
  logic [4:0]      pend_cause;
  logic [EA_W-1:0] pend_ea;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc        <= 1'b0;
      exc_data   <= 1'b0;
      exc_miss   <= 1'b0;
      exc_cause  <= '0;
      fault_ea   <= '0;
      pend_q     <= 1'b0;
      pend_miss  <= 1'b0;
      pend_cause <= '0;
      pend_ea    <= '0;
    end else begin
      exc <= 1'b0;
      if (pend_q) begin
        if (exc_ack) begin
          exc       <= 1'b1;
          exc_data  <= 1'b1;
          exc_miss  <= pend_miss;
          exc_cause <= pend_cause;
          fault_ea  <= pend_ea;
          pend_q    <= 1'b0;
        end
      end else if (f_flt) begin
        exc       <= 1'b1;
        exc_data  <= 1'b0;
        exc_miss  <= f_miss;
        exc_cause <= f_cause;
        fault_ea  <= f_ea;
        if (d_flt) begin
          pend_q     <= 1'b1;
          pend_miss  <= d_miss;
          pend_cause <= d_cause;
          pend_ea    <= d_ea;
        end
      end else if (d_flt) begin
        exc       <= 1'b1;
        exc_data  <= 1'b1;
        exc_miss  <= d_miss;
        exc_cause <= d_cause;
        fault_ea  <= d_ea;
      end
    end
  end

  assign exc_vec = exc_data ? (exc_miss ? VEC_DMISS : VEC_DERR)
                            : (exc_miss ? VEC_IMISS : VEC_IERR);

  p_xlat_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !(f_req && f_xlat_en) && !(d_req && d_xlat_en)) |=> !exc);
  p_miss_no_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc && exc_miss) |-> (exc_cause == 5'b0));
  p_err_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc && !exc_miss) |-> (exc_cause != 5'b0));
  p_guard_fetch_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc && exc_data) |-> !exc_cause[3]);
  p_clean_data_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc && !exc_data) |-> !exc_cause[4]);
  p_ea_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !exc |-> $stable(fault_ea));
  p_fetch_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && f_req && f_xlat_en && !f_hit && d_req && d_xlat_en && !d_hit)
    |=> (exc && !exc_data && pend_q));
  p_parked_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !exc_ack) |=> !exc);

endmodule

// File: tb/sim_tlb_fault_classifier.sv
module sim_tlb_fault_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int EA_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic f_req, f_xlat_en, f_hit, f_seg_ok, f_page_ok, f_exec_ok, f_guarded;
  logic [EA_W-1:0] f_ea, d_ea;
  logic d_req, d_xlat_en, d_hit, d_seg_ok, d_page_ok, d_rd_ok, d_wr_ok, d_dirty, exc_ack;
  logic [1:0] d_kind;
  logic exc, exc_data, exc_miss;
  logic [15:0] exc_vec;
  logic [4:0] exc_cause;
  logic [EA_W-1:0] fault_ea;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_fault_classifier #(.EA_W(EA_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .f_req(f_req), .f_xlat_en(f_xlat_en), .f_hit(f_hit), .f_seg_ok(f_seg_ok),
    .f_page_ok(f_page_ok), .f_exec_ok(f_exec_ok), .f_guarded(f_guarded), .f_ea(f_ea),
    .d_req(d_req), .d_xlat_en(d_xlat_en), .d_hit(d_hit), .d_kind(d_kind),
    .d_seg_ok(d_seg_ok), .d_page_ok(d_page_ok), .d_rd_ok(d_rd_ok), .d_wr_ok(d_wr_ok),
    .d_dirty(d_dirty), .d_ea(d_ea), .exc_ack(exc_ack),
    .exc(exc), .exc_data(exc_data), .exc_miss(exc_miss), .exc_vec(exc_vec),
    .exc_cause(exc_cause), .fault_ea(fault_ea));

  typedef struct {
    logic        side;
    logic        miss;
    logic [4:0]  cause;
    logic [31:0] ea;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0, errors = 0;
  logic [31:0] last_ea = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic side, input logic miss, input logic [4:0] cause,
                      input logic [31:0] ea, input string tag);
    item_t it;
    it.side = side; it.miss = miss; it.cause = cause; it.ea = ea; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle_inputs();
    f_req = 0; f_xlat_en = 1; f_hit = 1; f_seg_ok = 1; f_page_ok = 1; f_exec_ok = 1; f_guarded = 0;
    f_ea = '0;
    d_req = 0; d_xlat_en = 1; d_hit = 1; d_kind = 2'b00; d_seg_ok = 1; d_page_ok = 1;
    d_rd_ok = 1; d_wr_ok = 1; d_dirty = 1; d_ea = '0; exc_ack = 0;
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      idle_inputs();
    end
  endtask

  task automatic fetch(input logic xl, input logic hit, input logic seg, input logic pg,
                       input logic ex, input logic gd, input logic [31:0] ea);
    f_req = 1; f_xlat_en = xl; f_hit = hit; f_seg_ok = seg; f_page_ok = pg;
    f_exec_ok = ex; f_guarded = gd; f_ea = ea;
  endtask

  task automatic data(input logic xl, input logic hit, input logic [1:0] kind, input logic seg,
                      input logic pg, input logic rd, input logic wr, input logic dirty,
                      input logic [31:0] ea);
    d_req = 1; d_xlat_en = xl; d_hit = hit; d_kind = kind; d_seg_ok = seg; d_page_ok = pg;
    d_rd_ok = rd; d_wr_ok = wr; d_dirty = dirty; d_ea = ea;
  endtask

  // monitor: compares each reported exception against the scoreboard
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && exc) begin
      if (sb.size() == 0) begin
        check(0, "R3/R10", "unexpected exception ea", fault_ea, 32'h0);
      end else begin
        item_t it;
        logic [15:0] ev;
        it = sb.pop_front();
        ev = it.side ? (it.miss ? 16'h1200 : 16'h1400) : (it.miss ? 16'h1100 : 16'h1300);
        check(exc_data == it.side && exc_miss == it.miss && exc_vec == ev &&
              exc_cause == it.cause && fault_ea == it.ea, it.tag, "report {side,miss,vec,cause}",
              {exc_data, exc_miss, exc_vec, 9'b0, exc_cause},
              {it.side, it.miss, ev, 9'b0, it.cause});
        last_ea = it.ea;
      end
    end
  end

  task automatic finish_run();
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(0, it.tag, "missing exception ea", 32'h0, it.ea);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "watchdog", "timeout", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    check(exc == 0 && exc_cause == 0 && fault_ea == 0, "R12", "reset state",
          {exc, exc_cause, 26'b0}, 32'h0);
    rst_n = 1;
    tick(1);

    // R1 fetch miss
    fetch(1, 0, 1, 1, 1, 0, 32'h0000_1000); push(0, 1, 5'b0, 32'h0000_1000, "R1"); tick(2);
    // R2 data miss
    data(1, 0, 2'b00, 1, 1, 1, 1, 1, 32'h0000_2000); push(1, 1, 5'b0, 32'h0000_2000, "R2"); tick(2);
    // R3 translation off on each side
    fetch(0, 0, 0, 0, 0, 1, 32'h0000_3000); tick(1);
    data(0, 0, 2'b01, 0, 0, 0, 0, 0, 32'h0000_3004); tick(1);
    fetch(0, 1, 1, 1, 1, 1, 32'h0000_3008); data(0, 1, 2'b01, 1, 1, 1, 1, 0, 32'h0000_300c); tick(2);
    check(fault_ea == 32'h0000_2000, "R3", "fault_ea untouched", fault_ea, 32'h0000_2000);
    // R7 miss priority over bad attributes
    fetch(1, 0, 0, 0, 0, 1, 32'h0000_4000); push(0, 1, 5'b0, 32'h0000_4000, "R7"); tick(1);
    data(1, 0, 2'b01, 0, 0, 0, 0, 0, 32'h0000_4004); push(1, 1, 5'b0, 32'h0000_4004, "R7"); tick(2);
    // R4 single fetch error causes
    fetch(1, 1, 1, 0, 1, 0, 32'h0000_5000); push(0, 0, 5'b00001, 32'h0000_5000, "R4"); tick(1);
    fetch(1, 1, 0, 1, 1, 0, 32'h0000_5004); push(0, 0, 5'b00010, 32'h0000_5004, "R4"); tick(1);
    fetch(1, 1, 1, 1, 0, 0, 32'h0000_5008); push(0, 0, 5'b00100, 32'h0000_5008, "R4"); tick(1);
    fetch(1, 1, 1, 1, 1, 1, 32'h0000_500c); push(0, 0, 5'b01000, 32'h0000_500c, "R4"); tick(1);
    fetch(1, 1, 1, 1, 1, 0, 32'h0000_5010); tick(2);
    // R8 combined fetch causes
    fetch(1, 1, 0, 0, 0, 1, 32'h0000_6000); push(0, 0, 5'b01111, 32'h0000_6000, "R8"); tick(2);
    // R5 data errors by access type
    data(1, 1, 2'b00, 1, 1, 0, 1, 1, 32'h0000_7000); push(1, 0, 5'b00100, 32'h0000_7000, "R5"); tick(1);
    data(1, 1, 2'b01, 1, 1, 1, 0, 1, 32'h0000_7004); push(1, 0, 5'b00100, 32'h0000_7004, "R5"); tick(1);
    data(1, 1, 2'b10, 1, 1, 0, 1, 1, 32'h0000_7008); push(1, 0, 5'b00100, 32'h0000_7008, "R5"); tick(1);
    data(1, 1, 2'b01, 1, 1, 0, 1, 1, 32'h0000_700c); tick(1);
    data(1, 1, 2'b11, 1, 0, 1, 1, 1, 32'h0000_7010); push(1, 0, 5'b00001, 32'h0000_7010, "R5"); tick(1);
    data(1, 1, 2'b00, 0, 1, 1, 1, 1, 32'h0000_7014); push(1, 0, 5'b00010, 32'h0000_7014, "R5"); tick(2);
    // R6 clean-page write
    data(1, 1, 2'b01, 1, 1, 1, 1, 0, 32'h0000_8000); push(1, 0, 5'b10000, 32'h0000_8000, "R6"); tick(1);
    data(1, 1, 2'b00, 1, 1, 1, 1, 0, 32'h0000_8004); tick(1);
    data(1, 1, 2'b10, 1, 1, 1, 1, 0, 32'h0000_8008); tick(1);
    data(1, 1, 2'b01, 1, 1, 1, 0, 0, 32'h0000_800c); push(1, 0, 5'b10100, 32'h0000_800c, "R8"); tick(3);
    // R11 address hold and single-cycle strobe
    check(exc == 0, "R11", "strobe low after report", {31'b0, exc}, 32'h0);
    check(fault_ea == 32'h0000_800c, "R11", "fault_ea held", fault_ea, 32'h0000_800c);
    // R9 / R10 simultaneous faults
    fetch(1, 0, 1, 1, 1, 0, 32'h0000_9000);
    data(1, 1, 2'b01, 1, 1, 1, 0, 1, 32'h0000_9004);
    push(0, 1, 5'b0, 32'h0000_9000, "R9"); push(1, 0, 5'b00100, 32'h0000_9004, "R9");
    tick(2);
    fetch(1, 0, 1, 1, 1, 0, 32'h0000_9100); data(1, 0, 2'b00, 1, 1, 1, 1, 1, 32'h0000_9104); tick(2);
    check(fault_ea == 32'h0000_9000 && sb.size() == 1, "R10", "parked fault still pending",
          fault_ea, 32'h0000_9000);
    exc_ack = 1; tick(2);
    check(fault_ea == 32'h0000_9004, "R9", "data fault address after ack", fault_ea, 32'h0000_9004);
    exc_ack = 1; tick(2);
    check(fault_ea == 32'h0000_9004 && last_ea == 32'h0000_9004, "R10", "stray ack no effect",
          fault_ea, 32'h0000_9004);
    tick(2);
    finish_run();
  end
endmodule